// File: doc/BRIEF.md
# Memory ECC Encoder/Checker with Check-Code Error Injection

This block protects 64-bit memory words with an 8-bit single-error-correcting, double-error-detecting code. On the write side, it computes the code for each word, XORs it with a programmable injection mask, and hands data and code to storage one cycle later. On the read side, it takes a word and its stored code from storage. It corrects any single-bit error and flags corrected and uncorrectable errors, both in the same cycle.

The injection mask lets software exercise the error-detection path on purpose. Loading a nonzero mask makes every later write store a corrupted code. Reading those locations back then raises an error flag. A mask of zero, the reset value, turns injection off. A separate enable bit, also off after reset, turns checking and correction on. While checking is off, read data passes through untouched.

Top module: `ecc_inject`

## Requirements
- R1: One cycle after a cycle with `wr_valid` high, `st_valid` is high, `st_data` equals the written word, and `st_code` equals the check code of that word XORed with the mask. After a cycle with `wr_valid` low, `st_valid` is low.
  - The check code is defined as follows. Data bit i is given the i-th integer, counting from 3 upward, that is not a power of two (bit 0 gets 3, bit 1 gets 5, bit 2 gets 6, and so on).
  - Code bit k, for k from 0 to 6, is the XOR of the data bits whose number has bit k set.
  - Code bit 7 is the XOR of all 64 data bits and code bits 0 to 6.
- R2: After reset the mask is zero, so writes store the unmodified check code.
- R3: A configuration write (`cfg_we` high) takes effect at the next clock edge. A memory write in the same cycle still uses the previous mask, and every later write uses the new mask.
- R4: After reset, checking is disabled. While it is disabled, `rd_dout` equals `rd_data` and both error flags are low, whatever the stored code.
- R5: With checking enabled, reading a word with its correct code gives `rd_dout` equal to `rd_data` with both flags low.
- R6: With checking enabled, a word with exactly one flipped data bit is returned corrected, with `rd_corr` high and `rd_uncorr` low.
- R7: With checking enabled, a single flipped code bit (any of bits 0 to 7) leaves the data unchanged and raises `rd_corr`.
- R8: With checking enabled, any two flipped bits among the 72 stored bits raise `rd_uncorr` with `rd_corr` low, and `rd_dout` equals `rd_data`.
- R9: With checking enabled, a word written under a nonzero mask and read back unchanged raises `rd_corr` or `rd_uncorr`.
- R10: `rd_corr` and `rd_uncorr` are never high together, and both are low while `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mask | input | 8 | New injection mask |
| cfg_chk_en | input | 1 | New checking enable value |
| wr_valid | input | 1 | Write word valid |
| wr_data | input | 64 | Word to be written |
| st_valid | output | 1 | Storage write valid |
| st_data | output | 64 | Data to storage |
| st_code | output | 8 | Possibly masked check code to storage |
| rd_valid | input | 1 | Read word valid |
| rd_data | input | 64 | Data from storage |
| rd_code | input | 8 | Stored check code |
| rd_dout | output | 64 | Corrected read data |
| rd_corr | output | 1 | Single-bit error corrected |
| rd_uncorr | output | 1 | Uncorrectable error detected |

## Verification
The assertions check the following on every cycle:
- The two flags are never high together.
- The flags are low while no read is presented.
- The checker is a transparent bypass while disabled.
- The write pipeline has one cycle of latency.
- Clean and uncorrectable reads return raw data.
- A correction changes at most one bit.

Only the bench's scenarios can show the rest:
- That the stored code has the exact value defined in R1.
- The cycle at which a new mask first applies.
- That a masked write really reads back as an error.
- That every single-bit error is repaired to the original word.

// File: rtl/ecc_inject.sv
module ecc_inject #(
  parameter int DATA_W = 64,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CODE_W-1:0] cfg_mask,
  input  logic              cfg_chk_en,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              st_valid,
  output logic [DATA_W-1:0] st_data,
  output logic [CODE_W-1:0] st_code,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [CODE_W-1:0] rd_code,
  output logic [DATA_W-1:0] rd_dout,
  output logic              rd_corr,
  output logic              rd_uncorr
);
  localparam int HB = CODE_W - 1;
  localparam int CW = DATA_W + HB;

  function automatic logic [CODE_W-1:0] gen_code(input logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] c;
    int di;
    c  = '0;
    di = 0;
    for (int pos = 1; pos <= CW; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        for (int b = 0; b < HB; b++)
          if (((pos >> b) & 1) == 1) c[b] = c[b] ^ d[di];
        di++;
      end
    end
    c[CODE_W-1] = ^{d, c[HB-1:0]};
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] flip_at(input logic [DATA_W-1:0] d,
                                                input logic [HB-1:0] s);
    logic [DATA_W-1:0] r;
    int di;
    r  = d;
    di = 0;
    for (int pos = 1; pos <= CW; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (s == HB'(pos)) r[di] = ~r[di];
        di++;
      end
    end
    return r;
  endfunction

  logic [CODE_W-1:0] mask_q;
  logic              chk_en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q   <= '0;
      chk_en_q <= 1'b0;
    end else if (cfg_we) begin
      mask_q   <= cfg_mask;
      chk_en_q <= cfg_chk_en;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_valid <= 1'b0;
      st_data  <= '0;
      st_code  <= '0;
    end else begin
      st_valid <= wr_valid;
      if (wr_valid) begin
        st_data <= wr_data;
        st_code <= gen_code(wr_data) ^ mask_q;
      end
    end
  end

  logic [CODE_W-1:0] rd_calc;
  logic [HB-1:0]     syn;
  logic              odd_par, syn_ok, chk_act;

  assign rd_calc = gen_code(rd_data);
  assign syn     = rd_calc[HB-1:0] ^ rd_code[HB-1:0];
  assign odd_par = ^{rd_data, rd_code};
  assign syn_ok  = int'(syn) <= CW;
  assign chk_act = chk_en_q & rd_valid;

  assign rd_corr   = chk_act & odd_par & syn_ok;
  assign rd_uncorr = chk_act & ((~odd_par & (|syn)) | (odd_par & ~syn_ok));
  assign rd_dout   = rd_corr ? flip_at(rd_data, syn) : rd_data;
endmodule

// File: rtl/ecc_inject_chk.sv
module ecc_inject_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chk_en,
  input logic              wr_valid,
  input logic [DATA_W-1:0] wr_data,
  input logic              st_valid,
  input logic [DATA_W-1:0] st_data,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] rd_dout,
  input logic              rd_corr,
  input logic              rd_uncorr
);
  p_wr_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> st_valid && st_data == $past(wr_data));
  p_wr_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> !st_valid);
  p_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_en |-> rd_dout == rd_data && !rd_corr && !rd_uncorr);
  p_clean_raw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_corr && !rd_uncorr) |-> rd_dout == rd_data);
  p_fix_one_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_corr |-> $countones(rd_dout ^ rd_data) <= 1);
  p_uncorr_raw_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_uncorr |-> rd_dout == rd_data);
  p_flag_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_corr, rd_uncorr}));
  p_flag_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> !rd_corr && !rd_uncorr);
endmodule

bind ecc_inject ecc_inject_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .chk_en(chk_en_q),
  .wr_valid(wr_valid), .wr_data(wr_data),
  .st_valid(st_valid), .st_data(st_data),
  .rd_valid(rd_valid), .rd_data(rd_data), .rd_dout(rd_dout),
  .rd_corr(rd_corr), .rd_uncorr(rd_uncorr)
);

// File: tb/ecc_inject_tb.sv
module ecc_inject_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_mask = '0;
  logic        cfg_chk_en = 1'b0;
  logic        wr_valid = 1'b0;
  logic [63:0] wr_data = '0;
  logic        st_valid;
  logic [63:0] st_data;
  logic [7:0]  st_code;
  logic        rd_valid = 1'b0;
  logic [63:0] rd_data = '0;
  logic [7:0]  rd_code = '0;
  logic [63:0] rd_dout;
  logic        rd_corr, rd_uncorr;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [7:0] cur_mask = '0;

  always #4 clk = ~clk;

  ecc_inject u_dut (.*);

  function automatic int dpos(input int i);
    int n, p;
    n = -1;
    p = 2;
    while (n < i) begin
      p++;
      if ((p & (p - 1)) != 0) n++;
    end
    return p;
  endfunction

  function automatic logic [7:0] ref_code(input logic [63:0] d);
    logic [7:0] c;
    c = '0;
    for (int i = 0; i < 64; i++) begin
      int p;
      p = dpos(i);
      for (int k = 0; k < 7; k++) if (((p >> k) & 1) == 1) c[k] ^= d[i];
    end
    c[7] = ^{d, c[6:0]};
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [71:0] act, input logic [71:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cfg(input logic [7:0] m, input logic en);
    @(negedge clk);
    cfg_we = 1; cfg_mask = m; cfg_chk_en = en;
    @(negedge clk);
    cfg_we = 0;
    cur_mask = m;
  endtask

  task automatic do_write(input logic [63:0] d, input logic [7:0] use_mask,
                          input string req, output logic [7:0] code_out);
    logic [7:0] e;
    wr_valid = 1; wr_data = d;
    @(negedge clk);
    wr_valid = 0;
    e = ref_code(d) ^ use_mask;
    check(st_valid && st_data == d && st_code == e, req, "write",
          {st_code, st_data}, {e, d});
    code_out = st_code;
  endtask

  task automatic do_read(input logic [63:0] d, input logic [7:0] c,
                         input logic [63:0] ed, input logic ec, input logic eu,
                         input string req);
    @(negedge clk);
    rd_valid = 1; rd_data = d; rd_code = c;
    #1;
    check(rd_dout == ed && rd_corr == ec && rd_uncorr == eu, req, "read",
          {6'd0, rd_corr, rd_uncorr, rd_dout}, {6'd0, ec, eu, ed});
    @(negedge clk);
    rd_valid = 0;
  endtask

  function automatic logic [71:0] flip72(input logic [71:0] w, input int f);
    logic [71:0] r;
    r = w;
    r[f] = ~r[f];
    return r;
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  c;
    logic [63:0] d;
    logic [71:0] w;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!st_valid, "R1", "reset st_valid", {71'd0, st_valid}, 72'd0);

    // R4: disabled after reset, corrupted code passes raw
    d = 64'h0123_4567_89ab_cdef;
    do_read(d ^ 64'h1, ref_code(d), d ^ 64'h1, 0, 0, "R4");

    // R2: reset mask zero
    @(negedge clk);
    do_write(64'hdead_beef_0000_ffff, 8'h00, "R2", c);
    do_write(64'h0, 8'h00, "R2", c);
    do_write('1, 8'h00, "R1", c);
    @(negedge clk);
    check(!st_valid, "R1", "idle st_valid", {71'd0, st_valid}, 72'd0);

    cfg(8'h00, 1);
    d = 64'h8000_0000_0000_0001;
    do_read(d, ref_code(d), d, 0, 0, "R5");

    // R6: data bit flips at edges and middle
    foreach (w[i]) if (i == 0 || i == 31 || i == 63) begin
      d = 64'hfeed_face_cafe_babe;
      do_read(d ^ (64'h1 << i), ref_code(d), d, 1, 0, "R6");
    end
    // R7: code bit flips incl. overall parity bit
    for (int k = 0; k < 8; k++) begin
      d = 64'h1357_9bdf_2468_ace0;
      do_read(d, ref_code(d) ^ (8'h1 << k), d, 1, 0, "R7");
    end
    // R8: double errors
    d = 64'h0f0f_0f0f_f0f0_f0f0;
    do_read(d ^ 64'h3, ref_code(d), d ^ 64'h3, 0, 1, "R8");
    do_read(d ^ 64'h8000_0000_0000_0000, ref_code(d) ^ 8'h80,
            d ^ 64'h8000_0000_0000_0000, 0, 1, "R8");

    // R3: mask change coincident with a write
    @(negedge clk);
    cfg_we = 1; cfg_mask = 8'h05; cfg_chk_en = 1;
    do_write(64'haaaa_5555_aaaa_5555, 8'h00, "R3", c);
    cfg_we = 0; cur_mask = 8'h05;
    do_write(64'haaaa_5555_aaaa_5555, 8'h05, "R3", c);
    // R9: masked write reads back as error
    d = 64'haaaa_5555_aaaa_5555;
    @(negedge clk);
    rd_valid = 1; rd_data = d; rd_code = c;
    #1;
    check(rd_corr || rd_uncorr, "R9", "masked 05 flag",
          {70'd0, rd_corr, rd_uncorr}, 72'd1);
    @(negedge clk);
    rd_valid = 0;
    cfg(8'h80, 1);
    do_write(d, 8'h80, "R3", c);
    do_read(d, c, d, 1, 0, "R9");
    cfg(8'h7f, 1);
    do_write(d, 8'h7f, "R3", c);
    do_read(d, c, d, 0, 1, "R9");

    // R4 again: disabling restores pass-through
    cfg(8'h00, 0);
    do_read(d ^ 64'h10, ref_code(d), d ^ 64'h10, 0, 0, "R4");
    cfg(8'h00, 1);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int nf, f1, f2;
      @(negedge clk);
      d = {$urandom, $urandom};
      do_write(d, 8'h00, "R1", c);
      w = {c, d};
      nf = $urandom_range(0, 2);
      f1 = $urandom_range(0, 71);
      f2 = (f1 + $urandom_range(1, 71)) % 72;
      if (nf >= 1) w = flip72(w, f1);
      if (nf == 2) w = flip72(w, f2);
      if (nf == 0) do_read(w[63:0], w[71:64], d, 0, 0, "R5");
      else if (nf == 1) do_read(w[63:0], w[71:64], d, 1, 0, f1 < 64 ? "R6" : "R7");
      else do_read(w[63:0], w[71:64], w[63:0], 0, 1, "R8");
    end

    @(negedge clk);
    check(!rd_corr && !rd_uncorr, "R10", "idle flags",
          {70'd0, rd_corr, rd_uncorr}, 72'd0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule